// File: doc/BRIEF.md
# NAND Prefetch and Postwrite Engine

This block moves a programmed number of bytes between a NAND data port and a small byte FIFO. In read (prefetch) mode it fetches bytes from the selected NAND device into the FIFO in bursts. The CPU or a DMA channel drains them through a one-byte FIFO read port. In write (postwrite) mode the CPU pushes bytes through the FIFO write port and the engine forwards them to the device. For 16-bit devices it pairs bytes into halfwords.

Software sets up a configuration word and a byte count, then sets a start bit. While a transfer runs, the configuration and the count are locked. The engine raises a DMA request when fetched data is waiting. A terminal-count event marks the end of the transfer. A threshold status reports when the FIFO fill level reaches the programmed threshold. Per-chip-select width straps tell the engine whether the selected device is 8 or 16 bits wide.

Top module: `nand_fifo_engine`

## Requirements
- R1: After reset the configuration register (address 0) reads 0x00004000, and the status register (address 3) and interrupt status (address 4) read 0. The DMA request, the interrupt and the NAND strobes are all low.
- R2: The configuration word has these fields. Bit 0 selects write mode, bit 2 enables the DMA request, bit 7 enables the FIFO data port, bits 14:8 hold the threshold and bits 26:24 hold the chip select. Writes to the configuration word and to the transfer count (address 1, 14 bits) are ignored while the start bit (address 2, bit 0) is set.
- R3: Setting the start bit in read mode loads the remaining count from the transfer count and empties the FIFO. Whenever the free space is at least the threshold, the engine fetches min(free space, remaining) bytes. The bytes leave the FIFO in NAND order, and the fill level never exceeds the FIFO depth.
- R4: For a chip select strapped 16-bit wide, each fetch reads one halfword, and the low byte enters the FIFO first. The count stays a byte count, and an odd final byte takes only the low half.
- R5: A FIFO read with the FIFO empty returns the last byte again and leaves the pointer at 0. A FIFO read in write mode returns 0.
- R6: With DMA enabled, the DMA request rises at the end of each fetch burst. It falls on the FIFO read that completes threshold reads since it rose, or on the read that empties the FIFO.
- R7: The status word gives the FIFO pointer in bits 30:24 and the remaining count in bits 13:0. Bit 16 is set when the pointer is at least the threshold. The pointer is the fill level in read mode. In write mode it is 64 minus the held byte.
- R8: When the remaining count reaches zero during a transfer, the start bit clears itself and interrupt status bit 1 (terminal count) is set.
- R9: In write mode with an 8-bit device, each accepted byte produces one NAND write strobe, with the byte in data bits 7:0.
- R10: In write mode with a 16-bit device, the first byte of a pair is held. The second byte produces one NAND write of {second, first}.
- R11: A FIFO write is ignored in read mode, when the remaining count is zero, or when the enable bit is clear.
- R12: Clearing the start bit by software forces the remaining count to zero and stops any further fetches. It does not set terminal count, and the data already in the FIFO can still be read.
- R13: Interrupt status bit 0 is set while the threshold flag is high, and bit 1 is set on terminal count. Both bits are sticky and clear when 1 is written to them. The interrupt output is the OR of (status AND enable), with the enable register at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fifo_rd | input | 1 | FIFO byte read strobe |
| fifo_rdata | output | 8 | Byte returned by the last FIFO read |
| fifo_wr | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO write byte |
| cs_wide | input | 8 | Per chip select: 1 means a 16-bit device |
| nand_cs | output | 3 | Selected chip select |
| nand_rd | output | 1 | NAND read strobe; data sampled in the same cycle |
| nand_rdata | input | 16 | NAND read data |
| nand_wr | output | 1 | NAND write strobe |
| nand_wdata | output | 16 | NAND write data |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the engine with its default 64-byte FIFO and 8 chip selects. At that depth, transfers of 90 to 200 bytes need several threshold-driven refills. Thresholds of 1, 8, 16, 32 and 64 cover single-byte refills through refills that wait for an empty FIFO. An odd byte count on a 16-bit device exercises the final half-used halfword. Write tests cover 8-bit forwarding, 16-bit pairing with the half-held pointer value, and the ignored-write cases. Further tests cover the configuration lock, a software stop and the DMA request edges.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    localparam int CS_W  = 3;
    localparam int THR_W = 7;
    localparam int CNT_W = 14;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd1;
    localparam logic [2:0] A_CTL  = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_IST  = 3'd4;
    localparam logic [2:0] A_IEN  = 3'd5;

    typedef struct packed {
        logic [CS_W-1:0]  cs;
        logic [THR_W-1:0] thr;
        logic             en;
        logic             dma_en;
        logic             wr_mode;
    } cfg_t;

    typedef enum logic {ST_IDLE, ST_FILL} seq_t;

    localparam cfg_t CFG_RESET = '{cs: '0, thr: 7'h40, en: 1'b0, dma_en: 1'b0, wr_mode: 1'b0};

    function automatic cfg_t cfg_unpack(input logic [31:0] w);
        cfg_t c;
        c.wr_mode = w[0];
        c.dma_en  = w[2];
        c.en      = w[7];
        c.thr     = w[14:8];
        c.cs      = w[26:24];
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.wr_mode;
        w[2]     = c.dma_en;
        w[7]     = c.en;
        w[14:8]  = c.thr;
        w[26:24] = c.cs;
        return w;
    endfunction

    // Burst size: smaller of free space and remaining count; a 16-bit device
    // only fetches whole halfwords unless the burst finishes the transfer.
    function automatic logic [CNT_W-1:0] burst_len(input logic [CNT_W-1:0] free,
                                                   input logic [CNT_W-1:0] rem,
                                                   input logic wide);
        logic [CNT_W-1:0] b;
        b = (free < rem) ? free : rem;
        if (wide && (b < rem)) b[0] = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/nfe_fifo.sv
module nfe_fifo #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             push_two,
    input  logic [15:0]      push_data,
    input  logic             pop_req,
    input  logic             zero_rd,
    output logic [OCC_W-1:0] count,
    output logic [7:0]       rdata
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic             pop;
    logic [OCC_W-1:0] n_in, n_out;

    always_comb begin
        pop   = pop_req && (count != '0);
        n_in  = push ? (push_two ? OCC_W'(2) : OCC_W'(1)) : '0;
        n_out = pop ? OCC_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data[7:0];
            if (push_two) mem[wptr + PTR_W'(1)] <= push_data[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
            rdata <= '0;
        end else begin
            if (zero_rd)  rdata <= 8'h00;
            else if (pop) rdata <= mem[rptr];
            if (flush) begin
                rptr  <= '0;
                wptr  <= '0;
                count <= '0;
            end else begin
                if (push) wptr <= wptr + (push_two ? PTR_W'(2) : PTR_W'(1));
                if (pop)  rptr <= rptr + PTR_W'(1);
                count <= count + n_in - n_out;
            end
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= OCC_W'(DEPTH));
    assert_push_room_R3: assert property (@(posedge clk) disable iff (rst)
        push |-> ({1'b0, count} + {1'b0, n_in} <= (OCC_W+1)'(DEPTH)));
    assert_empty_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !zero_rd && count == '0) |=> $stable(rdata));
endmodule

// File: rtl/nfe_regs.sv
module nfe_regs
    import nfe_pkg::*;
#(
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             running,
    input  logic [CNT_W-1:0] rem,
    input  logic [OCC_W-1:0] ptr_view,
    input  logic             thr_flag,
    input  logic             tc_pulse,
    output cfg_t             cfg,
    output logic [CNT_W-1:0] xfer,
    output logic             start_set,
    output logic             start_clr,
    output logic             irq
);
    logic [1:0] ien_q, ist_q, w1c;

    always_comb begin
        start_set = reg_wr && reg_addr == A_CTL && reg_wdata[0] && !running;
        start_clr = reg_wr && reg_addr == A_CTL && !reg_wdata[0] && running;
        w1c       = (reg_wr && reg_addr == A_IST) ? reg_wdata[1:0] : 2'b00;
        irq       = |(ist_q & ien_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            xfer  <= '0;
            ien_q <= '0;
            ist_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CFG && !running) cfg  <= cfg_unpack(reg_wdata);
            if (reg_wr && reg_addr == A_CNT && !running) xfer <= reg_wdata[CNT_W-1:0];
            if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[1:0];
            ist_q <= (ist_q & ~w1c) | {tc_pulse, thr_flag};
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:  reg_rdata = cfg_pack(cfg);
            A_CNT:  reg_rdata[CNT_W-1:0] = xfer;
            A_CTL:  reg_rdata[0] = running;
            A_STAT: begin
                reg_rdata[24 +: OCC_W] = ptr_view;
                reg_rdata[16]          = thr_flag;
                reg_rdata[CNT_W-1:0]   = rem;
            end
            A_IST:  reg_rdata[1:0] = ist_q;
            A_IEN:  reg_rdata[1:0] = ien_q;
            default: reg_rdata = '0;
        endcase
    end

    assert_cfg_lock_R2: assert property (@(posedge clk) disable iff (rst)
        running |=> ($stable(cfg) && $stable(xfer)));
    assert_w1c_R13: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_IST && reg_wdata[1] && !tc_pulse) |=> !ist_q[1]);
endmodule

// File: rtl/nfe_ctrl.sv
module nfe_ctrl
    import nfe_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OCC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] xfer,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             wide,
    input  logic             fifo_rd,
    input  logic             fifo_wr,
    input  logic [7:0]       fifo_wdata,
    input  logic [OCC_W-1:0] count,
    output logic             start_q,
    output logic [CNT_W-1:0] rem_q,
    output logic             push,
    output logic             push_two,
    output logic             flush,
    output logic             pop_req,
    output logic             zero_rd,
    output logic [OCC_W-1:0] ptr_view,
    output logic             thr_flag,
    output logic             tc_pulse,
    output logic             dma_req,
    output logic             nand_rd,
    output logic             nand_wr,
    output logic [15:0]      nand_wdata
);
    seq_t             state;
    logic [CNT_W-1:0] burst_q, free, blen, step, dec;
    logic             held_q, trig, fill, accept, burst_end, pop_ok;
    logic [7:0]       hold_byte, drained;

    always_comb begin
        free      = CNT_W'(DEPTH) - CNT_W'(count);
        blen      = burst_len(free, rem_q, wide);
        fill      = (state == ST_FILL);
        trig      = start_q && !cfg.wr_mode && !fill && rem_q != '0
                    && free >= CNT_W'(cfg.thr) && blen != '0;
        push_two  = fill && wide && burst_q >= CNT_W'(2);
        push      = fill;
        nand_rd   = fill;
        step      = push_two ? CNT_W'(2) : CNT_W'(1);
        burst_end = fill && burst_q == step;
        accept    = fifo_wr && cfg.en && cfg.wr_mode && rem_q != '0;
        dec       = fill ? step : (accept ? CNT_W'(1) : '0);
        tc_pulse  = start_q && !start_clr && dec != '0 && rem_q == dec;
        flush     = start_set && !cfg.wr_mode;
        pop_req   = fifo_rd && cfg.en && !cfg.wr_mode;
        zero_rd   = fifo_rd && cfg.en && cfg.wr_mode;
        pop_ok    = pop_req && count != '0;
        ptr_view  = cfg.wr_mode ? (OCC_W'(DEPTH) - OCC_W'(held_q)) : count;
        thr_flag  = 8'(ptr_view) >= 8'(cfg.thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= 1'b0;
            rem_q      <= '0;
            state      <= ST_IDLE;
            burst_q    <= '0;
            held_q     <= 1'b0;
            hold_byte  <= '0;
            nand_wr    <= 1'b0;
            nand_wdata <= '0;
        end else begin
            nand_wr <= 1'b0;
            if (start_clr) begin
                start_q <= 1'b0;
                rem_q   <= '0;
                state   <= ST_IDLE;
                burst_q <= '0;
            end else if (start_set) begin
                start_q <= 1'b1;
                rem_q   <= xfer;
                held_q  <= 1'b0;
                state   <= ST_IDLE;
            end else begin
                if (trig) begin
                    state   <= ST_FILL;
                    burst_q <= blen;
                end
                if (fill) begin
                    burst_q <= burst_q - step;
                    if (burst_end) state <= ST_IDLE;
                end
                if (dec != '0) rem_q <= rem_q - dec;
                if (tc_pulse) start_q <= 1'b0;
                if (accept) begin
                    if (wide && !held_q) begin
                        held_q    <= 1'b1;
                        hold_byte <= fifo_wdata;
                    end else begin
                        held_q     <= 1'b0;
                        nand_wr    <= 1'b1;
                        nand_wdata <= wide ? {fifo_wdata, hold_byte} : {8'h00, fifo_wdata};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_set) begin
            dma_req <= 1'b0;
            drained <= '0;
        end else if (burst_end && !start_clr) begin
            dma_req <= cfg.dma_en;
            drained <= '0;
        end else if (dma_req && pop_ok) begin
            drained <= drained + 8'd1;
            if (drained + 8'd1 >= 8'(cfg.thr) || count == OCC_W'(1)) dma_req <= 1'b0;
        end
    end

    assert_tc_stop_R8: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !start_q);
    assert_fetch_mode_R11: assert property (@(posedge clk) disable iff (rst)
        nand_rd |-> !cfg.wr_mode);
    assert_stop_zero_R12: assert property (@(posedge clk) disable iff (rst)
        start_clr |=> (rem_q == '0 && !nand_rd));
    assert_no_dma_wr_R6: assert property (@(posedge clk) disable iff (rst)
        cfg.wr_mode |-> !nand_rd);
endmodule

// File: rtl/nand_fifo_engine.sv
module nand_fifo_engine
    import nfe_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int NCS   = 1 << CS_W,
    localparam int OCC_W = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            fifo_rd,
    output logic [7:0]      fifo_rdata,
    input  logic            fifo_wr,
    input  logic [7:0]      fifo_wdata,
    input  logic [NCS-1:0]  cs_wide,
    output logic [CS_W-1:0] nand_cs,
    output logic            nand_rd,
    input  logic [15:0]     nand_rdata,
    output logic            nand_wr,
    output logic [15:0]     nand_wdata,
    output logic            dma_req,
    output logic            irq
);
    cfg_t             cfg;
    logic [CNT_W-1:0] xfer, rem;
    logic             start_set, start_clr, running, thr_flag, tc_pulse;
    logic             push, push_two, flush, pop_req, zero_rd;
    logic [OCC_W-1:0] count, ptr_view;

    assign nand_cs = cfg.cs;

    nfe_regs #(.OCC_W(OCC_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(running),
        .rem(rem), .ptr_view(ptr_view), .thr_flag(thr_flag), .tc_pulse(tc_pulse),
        .cfg(cfg), .xfer(xfer), .start_set(start_set), .start_clr(start_clr),
        .irq(irq)
    );

    nfe_ctrl #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_ctrl (
        .clk(clk), .rst(rst), .cfg(cfg), .xfer(xfer), .start_set(start_set),
        .start_clr(start_clr), .wide(cs_wide[cfg.cs]), .fifo_rd(fifo_rd),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .count(count),
        .start_q(running), .rem_q(rem), .push(push), .push_two(push_two),
        .flush(flush), .pop_req(pop_req), .zero_rd(zero_rd), .ptr_view(ptr_view),
        .thr_flag(thr_flag), .tc_pulse(tc_pulse), .dma_req(dma_req),
        .nand_rd(nand_rd), .nand_wr(nand_wr), .nand_wdata(nand_wdata)
    );

    nfe_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .push_two(push_two),
        .push_data(nand_rdata), .pop_req(pop_req), .zero_rd(zero_rd),
        .count(count), .rdata(fifo_rdata)
    );
endmodule

// File: tb/nand_fifo_engine_tb_top.sv
module nand_fifo_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_rd = 1'b0, fifo_wr = 1'b0;
    logic [7:0]  fifo_wdata = '0, fifo_rdata;
    logic [7:0]  cs_wide;
    logic [2:0]  nand_cs;
    logic        nand_rd, nand_wr, dma_req, irq;
    logic [15:0] nand_rdata, nand_wdata;

    int checks = 0;
    int errors = 0;
    logic       cur_wide = 1'b0;
    int         cur_cs = 0;
    int         nidx = 0;
    int         nrd_cnt = 0;
    int         wcnt = 0;
    logic [15:0] wlog [16];

    localparam int NV = 5;
    localparam int V_WIDE [NV] = '{0, 0, 1, 1, 0};
    localparam int V_CS   [NV] = '{0, 3, 1, 6, 7};
    localparam int V_CNT  [NV] = '{10, 100, 41, 130, 90};
    localparam int V_THR  [NV] = '{64, 16, 32, 8, 1};

    always #5 clk = ~clk;

    function automatic logic [7:0] bval(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign cs_wide    = cur_wide ? (8'b1 << cur_cs) : 8'b0;
    assign nand_rdata = cur_wide ? {bval(nidx + 1), bval(nidx)} : {8'h00, bval(nidx)};

    always @(posedge clk) begin
        if (nand_rd) begin
            nidx    <= nidx + (cur_wide ? 2 : 1);
            nrd_cnt <= nrd_cnt + 1;
        end
        if (nand_wr && wcnt < 16) begin
            wlog[wcnt] <= nand_wdata;
            wcnt       <= wcnt + 1;
        end
    end

    nand_fifo_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_rd(fifo_rd),
        .fifo_rdata(fifo_rdata), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .cs_wide(cs_wide), .nand_cs(nand_cs), .nand_rd(nand_rd),
        .nand_rdata(nand_rdata), .nand_wr(nand_wr), .nand_wdata(nand_wdata),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
        v = fifo_rdata;
    endtask

    task automatic push_b(input logic [7:0] b);
        @(negedge clk);
        fifo_wr = 1'b1; fifo_wdata = b;
        @(negedge clk);
        fifo_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drain n bytes, expecting NAND bytes first..first+n-1; returns mismatches.
    task automatic drain(input int first, input int n, output int bad);
        logic [31:0] s;
        logic [7:0]  v;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            int t = 0;
            rg_rd(3'd3, s);
            while (s[30:24] == 0 && t < 500) begin
                rg_rd(3'd3, s);
                t++;
            end
            pop(v);
            if (v !== bval(first + i)) bad++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, cfgw;
        logic [7:0]  v;
        int bad;

        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        rg_rd(3'd0, r); check("R1 config reset", r, 32'h0000_4000);
        rg_rd(3'd3, r); check("R1 status reset", r, 32'h0);
        rg_rd(3'd4, r); check("R1 irq status reset", r, 32'h0);
        check("R1 dma/irq/strobes low", {28'h0, dma_req, irq, nand_rd, nand_wr}, 32'h0);

        // R3/R4/R8 read-mode stream vectors
        for (int k = 0; k < NV; k++) begin
            rg_wr(3'd4, 32'h3);
            cur_wide = V_WIDE[k][0];
            cur_cs   = V_CS[k];
            cfgw = (32'(V_CS[k]) << 24) | (32'(V_THR[k]) << 8) | 32'h80;
            rg_wr(3'd0, cfgw);
            rg_rd(3'd0, r); check("R2 config field layout", r, cfgw);
            rg_wr(3'd1, 32'(V_CNT[k]));
            nidx = 0;
            rg_wr(3'd2, 32'h1);
            drain(0, V_CNT[k], bad);
            check(V_WIDE[k] != 0 ? "R4 16-bit stream order" : "R3 8-bit stream order",
                  32'(bad), 32'h0);
            wait_cyc(4);
            rg_rd(3'd2, r); check("R8 start self-clears", r, 32'h0);
            rg_rd(3'd4, r); check("R8 terminal count status", {31'h0, r[1]}, 32'h1);
            if (k == 0) begin
                pop(v);
                check("R5 empty read repeats last byte", {24'h0, v}, {24'h0, bval(9)});
                rg_rd(3'd3, r); check("R5 pointer stays 0", {25'h0, r[30:24]}, 32'h0);
            end
        end

        // R9 postwrite, 8-bit, and R2 lock
        cur_cs = 2; cur_wide = 1'b0;
        cfgw = (32'd2 << 24) | (32'd16 << 8) | 32'h81;
        rg_wr(3'd0, cfgw);
        rg_wr(3'd1, 32'd3);
        rg_rd(3'd4, r); rg_wr(3'd4, 32'h3);
        wcnt = 0;
        rg_wr(3'd2, 32'h1);
        rg_wr(3'd0, 32'h0000_1F81);
        rg_rd(3'd0, r); check("R2 config locked while running", r, cfgw);
        rg_wr(3'd1, 32'd99);
        rg_rd(3'd1, r); check("R2 count locked while running", r, 32'd3);
        push_b(8'hA5); push_b(8'h3C); push_b(8'h7E);
        wait_cyc(3);
        check("R9 write strobe count", 32'(wcnt), 32'd3);
        check("R9 first byte", {16'h0, wlog[0]}, 32'h00A5);
        check("R9 third byte", {16'h0, wlog[2]}, 32'h007E);
        rg_rd(3'd4, r); check("R8 write-mode terminal count", {31'h0, r[1]}, 32'h1);
        push_b(8'h55);
        wait_cyc(3);
        check("R11 write after count zero ignored", 32'(wcnt), 32'd3);
        pop(v);
        check("R5 read in write mode returns 0", {24'h0, v}, 32'h0);

        // R10 postwrite, 16-bit pairing
        cur_cs = 5; cur_wide = 1'b1;
        rg_wr(3'd0, (32'd5 << 24) | (32'd64 << 8) | 32'h81);
        rg_wr(3'd1, 32'd4);
        wcnt = 0;
        rg_wr(3'd2, 32'h1);
        push_b(8'h11);
        rg_rd(3'd3, r); check("R7 write-mode pointer with held byte", {25'h0, r[30:24]}, 32'd63);
        push_b(8'h22); push_b(8'h33); push_b(8'h44);
        wait_cyc(3);
        check("R10 halfword count", 32'(wcnt), 32'd2);
        check("R10 first pair", {16'h0, wlog[0]}, 32'h2211);
        check("R10 second pair", {16'h0, wlog[1]}, 32'h4433);

        // R11 write in read mode ignored
        cur_cs = 0; cur_wide = 1'b0;
        rg_wr(3'd0, (32'd64 << 8) | 32'h80);
        rg_wr(3'd1, 32'd5);
        nidx = 0; wcnt = 0;
        rg_wr(3'd2, 32'h1);
        wait_cyc(15);
        push_b(8'h99);
        wait_cyc(3);
        check("R11 write in read mode ignored", 32'(wcnt), 32'd0);
        drain(0, 5, bad);
        check("R3 short transfer data", 32'(bad), 32'h0);

        // R11 enable bit clear gates the data port
        rg_wr(3'd0, 32'h0000_4001);
        rg_wr(3'd1, 32'd2);
        rg_wr(3'd2, 32'h1);
        push_b(8'h77);
        wait_cyc(3);
        check("R11 write with enable clear ignored", 32'(wcnt), 32'd0);
        rg_rd(3'd3, r); check("R11 remaining unchanged", {18'h0, r[13:0]}, 32'd2);
        rg_wr(3'd2, 32'h0);

        // R12 software stop
        rg_wr(3'd0, (32'd64 << 8) | 32'h80);
        rg_wr(3'd1, 32'd200);
        rg_wr(3'd4, 32'h3);
        nidx = 0; nrd_cnt = 0;
        rg_wr(3'd2, 32'h1);
        wait_cyc(100);
        rg_wr(3'd2, 32'h0);
        rg_rd(3'd3, r); check("R12 stop: remaining 0, FIFO kept", r, 32'h4001_0000);
        drain(0, 64, bad);
        check("R12 buffered data drains", 32'(bad), 32'h0);
        wait_cyc(20);
        check("R12 no fetch after stop", 32'(nrd_cnt), 32'd64);
        rg_rd(3'd4, r); check("R12 stop sets no terminal count", {31'h0, r[1]}, 32'h0);

        // R6 DMA request
        rg_wr(3'd0, (32'd16 << 8) | 32'h84);
        rg_wr(3'd1, 32'd80);
        nidx = 0;
        rg_wr(3'd2, 32'h1);
        wait_cyc(100);
        check("R6 request after fill", {31'h0, dma_req}, 32'h1);
        for (int i = 0; i < 15; i++) pop(v);
        check("R6 request held below threshold", {31'h0, dma_req}, 32'h1);
        pop(v);
        check("R6 request drops after threshold reads", {31'h0, dma_req}, 32'h0);
        wait_cyc(40);
        check("R6 request after refill", {31'h0, dma_req}, 32'h1);
        rg_rd(3'd3, r); check("R7 full FIFO status", r, 32'h4001_0000);
        drain(16, 64, bad);
        check("R3 refill data order", 32'(bad), 32'h0);

        // R13 interrupt, R7 flag below threshold
        rg_wr(3'd0, (32'd16 << 8) | 32'h80);
        rg_wr(3'd1, 32'd10);
        rg_wr(3'd4, 32'h3);
        rg_wr(3'd5, 32'h2);
        nidx = 0;
        rg_wr(3'd2, 32'h1);
        wait_cyc(40);
        rg_rd(3'd3, r); check("R7 partial fill status", r, 32'h0A00_0000);
        rg_rd(3'd4, r); check("R13 threshold event stays clear", r, 32'h2);
        check("R13 irq on terminal count", {31'h0, irq}, 32'h1);
        rg_wr(3'd4, 32'h2);
        wait_cyc(1);
        check("R13 write-one clears", {31'h0, irq}, 32'h0);
        drain(0, 10, bad);
        check("R3 partial transfer data", 32'(bad), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule